// File: doc/BRIEF.md
# Serial Configuration Frame Parser

This block takes a bit-serial configuration stream, one bit for each cycle in which its bit enable is high. While it waits, it discards logic-1 idle fill. The first logic-0 bit starts a header. The header holds a fixed synchronisation pattern, a 24-bit length count and a short all-ones trailer.

After the header, the parser splits the payload into a parameterised number of data frames. Each frame is framed by one start bit and a group of stop bits. The data bits of each frame are presented as one parallel word with a single-cycle valid strobe. After the last frame comes an all-ones postamble. Any further logic-1 fill bits are then accepted until the bit total given by the length count is reached. At that point the done flag rises.

Any framing or format violation raises a sticky error flag. The parser then ignores its input until reset. The length count is defined as two less than the real bit total. The total includes eight leading fill bits that the header is assumed to carry, and these are counted whether or not they were observed.

Top module: `cfg_frame_parser`

## Requirements
- R1: While `bit_en` is low, the inputs have no effect. Logic-1 bits received before the first logic-0 bit are discarded as idle fill.
- R2: The first logic-0 bit begins a PRE_W-bit sync pattern, default 0010, compared first-received bit first against PRE_PAT from its MSB down. Any mismatching bit sets `cfg_err`.
- R3: The next LEN_W (24) bits are the length count, MSB first. The stream total is length + 2 bits, counted from FILL_W (8) assumed fill bits before the sync pattern. If that total is below the smallest legal stream, `cfg_err` is set when the last length bit is accepted.
- R4: The TRAIL_W (4) bits after the length count must all be 1, otherwise `cfg_err` is set.
- R5: Each of the NUM_FRAMES frames is a 0 start bit, then FRAME_W data bits, then STOP_W (3) stop bits that are each 1. A wrong start or stop bit sets `cfg_err`.
- R6: `frame_valid` is high for exactly one cycle, the cycle after the last data bit of a frame is accepted. At that time `frame_data` holds the frame's data, with the first-received bit at the MSB.
- R7: After the last frame, POST_W (4) postamble bits and then any extra fill bits must all be 1 until the total is reached. A 0 among them sets `cfg_err`.
- R8: `cfg_done` rises in the cycle after the bit that brings the count to the total. It is not set earlier, and it stays set.
- R9: `cfg_err` is sticky. `cfg_done` and `cfg_err` are never both high. Once either is set, input bits produce no further `frame_valid` and do not change either flag.
- R10: A synchronous active-high reset clears `frame_valid`, `frame_data`, `cfg_done` and `cfg_err`, and returns the parser to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` this cycle |
| bit_in | input | 1 | Serial stream bit |
| frame_data | output | FRAME_W | Data bits of the latest frame, first bit at MSB |
| frame_valid | output | 1 | One-cycle strobe for `frame_data` |
| cfg_done | output | 1 | Sticky: full stream received |
| cfg_err | output | 1 | Sticky: format violation seen |

## Verification
A slip in the frame position counter shows within one frame. It either mis-frames a stop or start bit and raises `cfg_err`, or it moves the strobe a cycle and corrupts the captured word. A wrong remaining-bit count shows only at the end of the stream, as `cfg_done` rising early or late against the arithmetic total. For this reason every good stream checks that `cfg_done` is low just before the final bit and high just after it. Lengths that add 0 to 8 extra fill bits expose off-by-one errors in the plus-two rule.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_LEN,
    ST_TRAIL,
    ST_FRAME,
    ST_POST,
    ST_FILL,
    ST_DONE,
    ST_FAIL
  } cfgp_state_e;
endpackage

// File: rtl/cfgp_shreg.sv
module cfgp_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/cfgp_remain.sv
module cfgp_remain #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (dec)  q <= q - W'(1);
  end

  assign last = (q == W'(1));
endmodule

// File: rtl/cfg_frame_parser.sv
module cfg_frame_parser
  import cfgp_pkg::*;
#(
  parameter int               FRAME_W    = 71,
  parameter int               NUM_FRAMES = 197,
  parameter int               STOP_W     = 3,
  parameter int               POST_W     = 4,
  parameter int               TRAIL_W    = 4,
  parameter int               LEN_W      = 24,
  parameter int               FILL_W     = 8,
  parameter int               PRE_W      = 4,
  parameter logic [PRE_W-1:0] PRE_PAT    = 4'b0010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame_data,
  output logic               frame_valid,
  output logic               cfg_done,
  output logic               cfg_err
);
  localparam int FRAME_BITS = 1 + FRAME_W + STOP_W;
  localparam int HDR_CNT    = FILL_W + PRE_W + LEN_W;
  localparam int BODY_MIN   = TRAIL_W + NUM_FRAMES * FRAME_BITS + POST_W;
  localparam int MIN_TOTAL  = HDR_CNT + BODY_MIN;
  localparam int REM_W      = LEN_W + 1;
  localparam int CW         = $clog2(LEN_W + 1);
  localparam int FW         = $clog2(FRAME_BITS + 1);
  localparam int NW         = $clog2(NUM_FRAMES + 1);

  cfgp_state_e      state;
  logic [CW-1:0]    scnt;
  logic [FW-1:0]    fpos;
  logic [NW-1:0]    fcnt;
  logic [PRE_W-2:0] pre_q;
  logic [LEN_W-1:0] len_q;
  logic [FRAME_W-1:0] dat_q;
  logic [LEN_W-1:0] len_next;
  logic [REM_W-1:0] total;
  logic             too_small;
  logic             len_last;
  logic             rem_load;
  logic             rem_dec;
  logic             rem_last;
  logic             dat_en;

  assign len_next  = {len_q[LEN_W-2:0], bit_in};
  assign total     = {1'b0, len_next} + REM_W'(2);
  assign too_small = total < REM_W'(MIN_TOTAL);
  assign len_last  = (state == ST_LEN) && (scnt == CW'(LEN_W - 1));
  assign rem_load  = bit_en && len_last && !too_small;
  assign rem_dec   = bit_en && (state inside {ST_TRAIL, ST_FRAME, ST_POST, ST_FILL});
  assign dat_en    = bit_en && (state == ST_FRAME) && (fpos != '0)
                     && (fpos <= FW'(FRAME_W));

  cfgp_shreg #(.W(LEN_W)) u_len_sr (
    .clk(clk), .rst(rst), .en(bit_en && state == ST_LEN), .din(bit_in), .q(len_q)
  );

  cfgp_shreg #(.W(FRAME_W)) u_dat_sr (
    .clk(clk), .rst(rst), .en(dat_en), .din(bit_in), .q(dat_q)
  );

  cfgp_remain #(.W(REM_W)) u_remain (
    .clk(clk), .rst(rst), .load(rem_load), .load_val(total - REM_W'(HDR_CNT)),
    .dec(rem_dec), .last(rem_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      scnt        <= '0;
      fpos        <= '0;
      fcnt        <= '0;
      pre_q       <= '0;
      frame_data  <= '0;
      frame_valid <= 1'b0;
      cfg_done    <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (bit_en) begin
        unique case (state)
          ST_IDLE: if (!bit_in) begin
            state <= ST_PRE;
            scnt  <= CW'(1);
            pre_q <= PRE_PAT[PRE_W-2:0];
          end
          ST_PRE: begin
            if (bit_in != pre_q[PRE_W-2]) begin
              state <= ST_FAIL; cfg_err <= 1'b1;
            end else if (scnt == CW'(PRE_W - 1)) begin
              state <= ST_LEN; scnt <= '0;
            end else begin
              scnt  <= scnt + CW'(1);
              pre_q <= pre_q << 1;
            end
          end
          ST_LEN: begin
            if (len_last) begin
              scnt <= '0;
              if (too_small) begin
                state <= ST_FAIL; cfg_err <= 1'b1;
              end else begin
                state <= ST_TRAIL;
              end
            end else begin
              scnt <= scnt + CW'(1);
            end
          end
          ST_TRAIL: begin
            if (!bit_in) begin
              state <= ST_FAIL; cfg_err <= 1'b1;
            end else if (scnt == CW'(TRAIL_W - 1)) begin
              state <= ST_FRAME; fpos <= '0; fcnt <= '0;
            end else begin
              scnt <= scnt + CW'(1);
            end
          end
          ST_FRAME: begin
            if (fpos == '0) begin
              if (bit_in) begin
                state <= ST_FAIL; cfg_err <= 1'b1;
              end else begin
                fpos <= FW'(1);
              end
            end else if (fpos <= FW'(FRAME_W)) begin
              if (fpos == FW'(FRAME_W)) begin
                frame_valid <= 1'b1;
                frame_data  <= {dat_q[FRAME_W-2:0], bit_in};
              end
              fpos <= fpos + FW'(1);
            end else if (!bit_in) begin
              state <= ST_FAIL; cfg_err <= 1'b1;
            end else if (fpos == FW'(FRAME_BITS - 1)) begin
              fpos <= '0;
              if (fcnt == NW'(NUM_FRAMES - 1)) begin
                state <= ST_POST; scnt <= '0;
              end else begin
                fcnt <= fcnt + NW'(1);
              end
            end else begin
              fpos <= fpos + FW'(1);
            end
          end
          ST_POST: begin
            if (!bit_in) begin
              state <= ST_FAIL; cfg_err <= 1'b1;
            end else if (scnt == CW'(POST_W - 1)) begin
              if (rem_last) begin
                state <= ST_DONE; cfg_done <= 1'b1;
              end else begin
                state <= ST_FILL;
              end
            end else begin
              scnt <= scnt + CW'(1);
            end
          end
          ST_FILL: begin
            if (!bit_in) begin
              state <= ST_FAIL; cfg_err <= 1'b1;
            end else if (rem_last) begin
              state <= ST_DONE; cfg_done <= 1'b1;
            end
          end
          ST_DONE, ST_FAIL: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int NUM_FRAMES = 197
) (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic frame_valid,
  input logic cfg_done,
  input logic cfg_err
);
  logic [31:0] vcount;

  always_ff @(posedge clk) begin
    if (rst)              vcount <= '0;
    else if (frame_valid) vcount <= vcount + 32'd1;
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid); // R6
  AST_FRAME_LIMIT: assert property (@(posedge clk) disable iff (rst)
    vcount <= 32'(NUM_FRAMES)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> cfg_done); // R8
  AST_DONE_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |-> $past(bit_en)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cfg_done && cfg_err)); // R9
  AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (cfg_done || cfg_err) |=> !frame_valid); // R9
  AST_NO_EN_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> (!frame_valid && $stable(cfg_done) && $stable(cfg_err))); // R1
endmodule

bind cfg_frame_parser cfgp_checker #(.NUM_FRAMES(NUM_FRAMES)) u_cfgp_checker (
  .clk(clk), .rst(rst), .bit_en(bit_en), .frame_valid(frame_valid),
  .cfg_done(cfg_done), .cfg_err(cfg_err)
);

// File: tb/cfg_frame_parser_bench.sv
`timescale 1ns/1ps
module cfg_frame_parser_bench;
  localparam int FW = 8;
  localparam int NF = 3;
  localparam int FRAME_BITS = 12;
  localparam int MIN_LEN = 78;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic bit_in = 1'b1;
  logic [FW-1:0] frame_data;
  logic frame_valid, cfg_done, cfg_err;

  int total = 0;
  int bad = 0;
  logic sb [0:511];
  int n;
  int base;
  logic [FW-1:0] cap [0:15];
  int ncap;

  always #2.5 clk = ~clk;

  cfg_frame_parser #(.FRAME_W(FW), .NUM_FRAMES(NF)) u_cfg_frame_parser (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .frame_data(frame_data), .frame_valid(frame_valid),
    .cfg_done(cfg_done), .cfg_err(cfg_err)
  );

  always @(negedge clk) begin
    if (!rst && frame_valid && ncap < 16) begin
      cap[ncap] = frame_data;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] pat(input int seed, input int f);
    return FW'(seed * 37 + f * 11 + 5);
  endfunction

  task automatic push(input logic b);
    sb[n] = b;
    n++;
  endtask

  task automatic build(input int idle, input int extra, input int len_adj, input int seed);
    logic [23:0] len;
    n = 0;
    for (int i = 0; i < idle; i++) push(1'b1);
    base = n;
    push(1'b0); push(1'b0); push(1'b1); push(1'b0);
    len = 24'(MIN_LEN + extra + len_adj);
    for (int i = 23; i >= 0; i--) push(len[i]);
    for (int i = 0; i < 4; i++) push(1'b1);
    for (int f = 0; f < NF; f++) begin
      logic [FW-1:0] d;
      d = pat(seed, f);
      push(1'b0);
      for (int i = FW - 1; i >= 0; i--) push(d[i]);
      for (int i = 0; i < 3; i++) push(1'b1);
    end
    for (int i = 0; i < 4; i++) push(1'b1);
    for (int i = 0; i < extra; i++) push(1'b1);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0; bit_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    ncap = 0;
  endtask

  task automatic send(input logic b, input int gap);
    bit_en = 1'b1; bit_in = b;
    @(negedge clk);
    for (int g = 0; g < gap; g++) begin
      bit_en = 1'b0; bit_in = g[0];
      @(negedge clk);
    end
    bit_en = 1'b0;
  endtask

  task automatic run(input int gap, input bit check_timing);
    do_reset();
    for (int i = 0; i < n; i++) begin
      if (check_timing && i == n - 1)
        chk(cfg_done == 1'b0, "R8 done early", cfg_done, 0);
      send(sb[i], gap);
    end
  endtask

  task automatic expect_err(input string req, input int frames_ok);
    chk(cfg_err == 1'b1, req, cfg_err, 1);
    chk(cfg_done == 1'b0, "R9 done with err", cfg_done, 0);
    chk(ncap == frames_ok, "R9 frames before err", ncap, frames_ok);
  endtask

  initial begin
    ncap = 0;
    @(negedge clk);
    @(negedge clk);
    chk(frame_valid == 0 && cfg_done == 0 && cfg_err == 0, "R10 reset", {frame_valid, cfg_done, cfg_err}, 0);
    rst = 1'b0;

    // Good streams: R1 idle and gaps, R3 length+2, R6 data, R7 fill, R8 timing
    for (int idle = 0; idle < 10; idle += 4) begin
      for (int extra = 0; extra <= 8; extra += 4) begin
        for (int gap = 0; gap < 3; gap += 2) begin
          int seed;
          seed = idle * 7 + extra * 3 + gap;
          build(idle, extra + (gap == 2 ? 1 : 0), 0, seed);
          run(gap, 1'b1);
          chk(cfg_done == 1'b1, "R8 done", cfg_done, 1);
          chk(cfg_err == 1'b0, "R3 no err", cfg_err, 0);
          chk(ncap == NF, "R6 frame count", ncap, NF);
          for (int f = 0; f < NF; f++)
            chk(cap[f] == pat(seed, f), "R6 data", cap[f], pat(seed, f));
        end
      end
    end

    // R9: input after done is ignored
    build(2, 0, 0, 99);
    run(0, 1'b1);
    for (int i = 0; i < 24; i++) send(i[0], 0);
    chk(cfg_done == 1'b1 && cfg_err == 1'b0, "R9 after done", {cfg_done, cfg_err}, 2);
    chk(ncap == NF, "R9 no valid after done", ncap, NF);

    // R10: reset mid-stream, then a full good stream
    build(0, 2, 0, 12);
    do_reset();
    for (int i = 0; i < 40; i++) send(sb[i], 0);
    run(0, 1'b1);
    chk(cfg_done == 1'b1 && ncap == NF, "R10 restart", ncap, NF);

    // R2: sync pattern mismatch
    for (int p = 1; p < 4; p++) begin
      build(3, 0, 0, p);
      sb[base + p] = ~sb[base + p];
      run(0, 1'b0);
      expect_err("R2 sync mismatch", 0);
    end

    // R3: length too small
    build(1, 0, -1, 4);
    run(0, 1'b0);
    expect_err("R3 short length", 0);

    // R4: trailer zero
    for (int p = 0; p < 4; p++) begin
      build(0, 0, 0, p);
      sb[base + 28 + p] = 1'b0;
      run(0, 1'b0);
      expect_err("R4 trailer", 0);
    end

    // R5: bad start bit and each stop bit in every frame
    for (int f = 0; f < NF; f++) begin
      build(1, 0, 0, f);
      sb[base + 32 + f * FRAME_BITS] = 1'b1;
      run(1, 1'b0);
      expect_err("R5 start bit", f);
      for (int s = 0; s < 3; s++) begin
        build(1, 0, 0, f + s);
        sb[base + 32 + f * FRAME_BITS + 1 + FW + s] = 1'b0;
        run(0, 1'b0);
        expect_err("R5 stop bit", f + 1);
      end
    end

    // R7: zero in postamble or fill; further input after err ignored (R9)
    for (int p = 0; p < 4; p++) begin
      build(0, 0, 0, p);
      sb[base + 32 + NF * FRAME_BITS + p] = 1'b0;
      run(0, 1'b0);
      expect_err("R7 postamble", NF);
    end
    build(0, 5, 0, 8);
    sb[base + 32 + NF * FRAME_BITS + 4 + 2] = 1'b0;
    run(0, 1'b0);
    expect_err("R7 fill", NF);
    for (int i = 0; i < 20; i++) send(i[1], 0);
    chk(cfg_err == 1'b1 && cfg_done == 1'b0, "R9 after err", {cfg_done, cfg_err}, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule